// File: doc/BRIEF.md
# I2C Host Control and FIFO Register File

This block is the software-facing half of an I2C host controller. A CPU reaches it over a simple 32-bit register bus. One register address carries data both ways. A write pushes a 9-bit entry into the transmit queue, and bit 8 of that entry marks an address byte. A read pulls a byte from the receive queue.

Status, interrupt cause, interrupt enable and write-one-to-clear registers report progress. Timing and byte-count registers hold settings for the bit-level protocol engine. A reset register flushes either queue or starts a forced bus reset.

The protocol engine sits beside this block. It drains the transmit queue and fills the receive queue. It signals completion, missing acknowledge and lost arbitration as one-cycle pulses. It reports its busy flags, its byte counters and the end of a bus reset.

Register bus reads are combinational on `addr_i`. Writes, queue pushes and pops take effect at the rising clock edge of the accepted access.

Top module: `i2c_host_csr`

## Requirements
- R1: After reset all stored registers read 0, the status register reads 0x0000_0003 (TX empty, TX not full), `irq_o` is low, `bus_rst_o` is low and `tx_valid_o` is low.
- R2: The configuration registers keep the low CFG_W bits written to them, read those bits back zero-extended, and drive them on their outputs. The registers and their outputs are: 0x0C slave address, 0x10 SCL period, 0x14 SCL low time, 0x18 repeated-start/stop setup, 0x1C data setup, 0x40 TX byte count, 0x44 RX byte count, 0x50 bus control. Offsets 0x38 and 0x3C are storage only. Offsets 0x08 and 0x30 read 0 and ignore writes.
- R3: A write to offset 0x04 pushes `wdata_i[8:0]` into the FIFO_DEPTH-entry transmit queue. The engine sees the oldest entry on `tx_data_o` while `tx_valid_o` is high, and `tx_pop_i` removes it. A push to a full queue is ignored.
- R4: A read of offset 0x04 returns the oldest receive byte in bits 7:0 and removes it. A read of an empty queue returns 0 and changes nothing. A push from the engine into a full receive queue is ignored.
- R5: The status register at 0x2C has these bits: bit 12 `dev_busy_i`, bit 8 `bus_busy_i`, bit 3 RX full, bit 2 RX not empty, bit 1 TX not full, bit 0 TX empty. All other bits read 0.
- R6: The interrupt cause register at 0x20 is read-only, and its causes are sticky. The causes are:
  - bit 9 is set one cycle after the TX queue goes from non-empty to empty;
  - bit 4 is set by `evt_rx_done_i`;
  - bit 2 is set by `evt_nack_i`;
  - bit 1 is set by `evt_arb_lost_i`.
- R7: Writing 1 to a bit of the clear register at 0x28 clears that cause. A cause that is set and cleared in the same cycle ends up set. The clear register reads 0.
- R8: The enable register at 0x24 stores only bits 9, 4, 2 and 1. `irq_o` is high exactly when some cause bit and its enable bit are both 1.
- R9: In the reset register at 0x34, writing bit 2 empties the TX queue and writing bit 1 empties the RX queue. A flush wins over a push in the same cycle. Both bits read back 0.
- R10: Writing 1 to bit 0 of 0x34 raises `bus_rst_o`, and bit 0 reads 1 until `bus_rst_done_i` is seen. `bus_rst_o` then falls. Writing 0 to the bit does not end the reset.
- R11: A write to 0x00 stores bits 3:0 (bit 3 host mode, bit 2 start, bit 1 stop, bit 0 not-acknowledge). The stored bits drive `ctrl_o` and read back. `ctrl_wr_o` is high for exactly the one cycle after that write.
- R12: Offsets 0x48 and 0x4C read `tx_cnt_mon_i` and `rx_cnt_mon_i` zero-extended, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| ctrl_o | output | 4 | Stored control bits |
| ctrl_wr_o | output | 1 | One-cycle strobe after a control write |
| slave_addr_o | output | CFG_W | Target address setting |
| scl_cycle_o | output | CFG_W | SCL period in clocks |
| scl_low_o | output | CFG_W | SCL low time in clocks |
| setup_rs_o | output | CFG_W | Repeated-start/stop setup time |
| setup_dat_o | output | CFG_W | Data setup time |
| tx_bytes_o | output | CFG_W | TX byte count setting |
| rx_bytes_o | output | CFG_W | RX byte count setting |
| bus_ctl_o | output | CFG_W | Bus control setting |
| tx_valid_o | output | 1 | TX queue holds an entry |
| tx_data_o | output | 9 | Oldest TX entry, bit 8 = address tag |
| tx_pop_i | input | 1 | Engine removes the oldest TX entry |
| rx_push_i | input | 1 | Engine stores a received byte |
| rx_data_i | input | 8 | Received byte |
| evt_rx_done_i | input | 1 | Requested receive count reached |
| evt_nack_i | input | 1 | Target gave no acknowledge |
| evt_arb_lost_i | input | 1 | Arbitration lost |
| dev_busy_i | input | 1 | Engine busy |
| bus_busy_i | input | 1 | Bus busy |
| bus_rst_o | output | 1 | Forced bus reset in progress |
| bus_rst_done_i | input | 1 | Engine finished the bus reset |
| tx_cnt_mon_i | input | CFG_W | Engine TX byte counter |
| rx_cnt_mon_i | input | CFG_W | Engine RX byte counter |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take `req_i` as a single-cycle access. The control strobe check relies on this: it looks back exactly one cycle at the bus. The sticky-cause and clear-priority checks assume the engine's event inputs are clean single-cycle pulses. The bus-reset hold check assumes `bus_rst_done_i` only arrives while a reset is in progress. The stimulus follows these rules. Every bus access is one cycle followed by an idle cycle. Engine pulses last exactly one cycle. All inputs change on the falling clock edge, so they are stable at each rising edge.

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADR_W = 8;
  localparam int unsigned TX_W  = 9;
  localparam int unsigned RX_W  = 8;
  localparam int unsigned CTL_W = 4;

  typedef logic [ADR_W-1:0] off_t;

  localparam off_t OFF_CTRL    = 8'h00;
  localparam off_t OFF_DATA    = 8'h04;
  localparam off_t OFF_IRQ_ST  = 8'h20;
  localparam off_t OFF_IRQ_EN  = 8'h24;
  localparam off_t OFF_IRQ_CLR = 8'h28;
  localparam off_t OFF_STATUS  = 8'h2C;
  localparam off_t OFF_RST     = 8'h34;
  localparam off_t OFF_TX_MON  = 8'h48;
  localparam off_t OFF_RX_MON  = 8'h4C;

  // plain configuration storage
  localparam int NCFG      = 10;
  localparam int CFG_SLAVE = 0;
  localparam int CFG_CYC   = 1;
  localparam int CFG_LOW   = 2;
  localparam int CFG_RS    = 3;
  localparam int CFG_DSU   = 4;
  localparam int CFG_MON   = 5;
  localparam int CFG_NOISE = 6;
  localparam int CFG_TXB   = 7;
  localparam int CFG_RXB   = 8;
  localparam int CFG_BUS   = 9;

  function automatic off_t cfg_off(input int idx);
    case (idx)
      CFG_SLAVE: return 8'h0C;
      CFG_CYC:   return 8'h10;
      CFG_LOW:   return 8'h14;
      CFG_RS:    return 8'h18;
      CFG_DSU:   return 8'h1C;
      CFG_MON:   return 8'h38;
      CFG_NOISE: return 8'h3C;
      CFG_TXB:   return 8'h40;
      CFG_RXB:   return 8'h44;
      default:   return 8'h50;
    endcase
  endfunction

  localparam int unsigned IRQ_W  = 10;
  localparam int unsigned IRQ_TE = 9;
  localparam int unsigned IRQ_RB = 4;
  localparam int unsigned IRQ_NA = 2;
  localparam int unsigned IRQ_AL = 1;
  localparam logic [IRQ_W-1:0] IRQ_MASK = IRQ_W'((1 << IRQ_TE) | (1 << IRQ_RB) |
                                                 (1 << IRQ_NA) | (1 << IRQ_AL));

  localparam int unsigned ST_DB  = 12;
  localparam int unsigned ST_BB  = 8;
  localparam int unsigned ST_RFF = 3;
  localparam int unsigned ST_RNE = 2;
  localparam int unsigned ST_TNF = 1;
  localparam int unsigned ST_TFE = 0;

  localparam int unsigned RST_W   = 3;
  localparam int unsigned RST_TXF = 2;
  localparam int unsigned RST_RXF = 1;
  localparam int unsigned RST_BUS = 0;
endpackage

// File: rtl/i2c_csr_fifo.sv
// DEPTH must be a power of two (pointer wrap relies on it)
module i2c_csr_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] DEPTH_V = (PW+1)'(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [PW:0]  wr_q, rd_q, used;
  logic         do_push, do_pop;

  assign used    = wr_q - rd_q;
  assign empty_o = (used == '0);
  assign full_o  = (used == DEPTH_V);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign rdata_o = mem_q[rd_q[PW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q[PW-1:0]] <= wdata_i;
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && $stable(wr_q));

  assert_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= DEPTH_V);

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o && $stable(rd_q));

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/i2c_csr_irq.sv
module i2c_csr_irq #(
  parameter int unsigned     W    = 10,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] cause_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      en_q    <= '0;
    end else begin
      // set has priority so no event is lost
      cause_q <= ((cause_q & ~clr_i) | set_i) & MASK;
      if (en_we_i) en_q <= en_wdata_i & MASK;
    end
  end

  assign cause_o = cause_q;
  assign en_o    = en_q;
  assign irq_o   = |(cause_q & en_q);

  assert_cause_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & MASK) != '0 |=> (cause_q & $past(set_i & MASK)) == $past(set_i & MASK));

  assert_w1c_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~set_i & cause_q) != '0 |=> (cause_q & $past(clr_i & ~set_i)) == '0);
endmodule

// File: rtl/i2c_csr_rstctl.sv
module i2c_csr_rstctl
  import i2c_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [RST_W-1:0] wbits_i,
  input  logic             done_i,
  output logic             tx_flush_o,
  output logic             rx_flush_o,
  output logic             bus_rst_o
);
  logic bus_q;
  logic start;

  assign start      = wr_i & wbits_i[RST_BUS];
  assign tx_flush_o = wr_i & wbits_i[RST_TXF];
  assign rx_flush_o = wr_i & wbits_i[RST_RXF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bus_q <= 1'b0;
    else if (start)  bus_q <= 1'b1;
    else if (done_i) bus_q <= 1'b0;
  end

  assign bus_rst_o = bus_q;

  assert_bus_rst_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> bus_rst_o);

  assert_bus_rst_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o && !done_i |=> bus_rst_o);

  assert_bus_rst_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o && done_i && !start |=> !bus_rst_o);
endmodule

// File: rtl/i2c_host_csr.sv
module i2c_host_csr
  import i2c_csr_pkg::*;
#(
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [ADR_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [CTL_W-1:0] ctrl_o,
  output logic             ctrl_wr_o,
  output logic [CFG_W-1:0] slave_addr_o,
  output logic [CFG_W-1:0] scl_cycle_o,
  output logic [CFG_W-1:0] scl_low_o,
  output logic [CFG_W-1:0] setup_rs_o,
  output logic [CFG_W-1:0] setup_dat_o,
  output logic [CFG_W-1:0] tx_bytes_o,
  output logic [CFG_W-1:0] rx_bytes_o,
  output logic [CFG_W-1:0] bus_ctl_o,
  output logic             tx_valid_o,
  output logic [TX_W-1:0]  tx_data_o,
  input  logic             tx_pop_i,
  input  logic             rx_push_i,
  input  logic [RX_W-1:0]  rx_data_i,
  input  logic             evt_rx_done_i,
  input  logic             evt_nack_i,
  input  logic             evt_arb_lost_i,
  input  logic             dev_busy_i,
  input  logic             bus_busy_i,
  output logic             bus_rst_o,
  input  logic             bus_rst_done_i,
  input  logic [CFG_W-1:0] tx_cnt_mon_i,
  input  logic [CFG_W-1:0] rx_cnt_mon_i,
  output logic             irq_o
);
  logic acc_wr, acc_rd;
  logic [CFG_W-1:0] cfg_q [NCFG];
  logic [CTL_W-1:0] ctrl_q;
  logic             ctrl_wr_q;

  logic tx_empty, tx_full, tx_empty_q, tx_flush;
  logic rx_empty, rx_full, rx_flush;
  logic [RX_W-1:0] rx_head;

  logic [IRQ_W-1:0] irq_set, irq_clr, irq_cause, irq_en;
  logic [BUS_W-1:0] status_w;
  logic unused_wdata;

  assign acc_wr = req_i & we_i;
  assign acc_rd = req_i & ~we_i;
  assign unused_wdata = ^wdata_i;

  // configuration storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCFG; i++) cfg_q[i] <= '0;
    end else if (acc_wr) begin
      for (int i = 0; i < NCFG; i++)
        if (addr_i == cfg_off(i)) cfg_q[i] <= wdata_i[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      ctrl_wr_q <= 1'b0;
    end else begin
      ctrl_wr_q <= acc_wr && (addr_i == OFF_CTRL);
      if (acc_wr && (addr_i == OFF_CTRL)) ctrl_q <= wdata_i[CTL_W-1:0];
    end
  end

  assign ctrl_o       = ctrl_q;
  assign ctrl_wr_o    = ctrl_wr_q;
  assign slave_addr_o = cfg_q[CFG_SLAVE];
  assign scl_cycle_o  = cfg_q[CFG_CYC];
  assign scl_low_o    = cfg_q[CFG_LOW];
  assign setup_rs_o   = cfg_q[CFG_RS];
  assign setup_dat_o  = cfg_q[CFG_DSU];
  assign tx_bytes_o   = cfg_q[CFG_TXB];
  assign rx_bytes_o   = cfg_q[CFG_RXB];
  assign bus_ctl_o    = cfg_q[CFG_BUS];

  i2c_csr_rstctl u_rstctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (acc_wr && (addr_i == OFF_RST)),
    .wbits_i    (wdata_i[RST_W-1:0]),
    .done_i     (bus_rst_done_i),
    .tx_flush_o (tx_flush),
    .rx_flush_o (rx_flush),
    .bus_rst_o  (bus_rst_o)
  );

  i2c_csr_fifo #(.W(TX_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush),
    .push_i  (acc_wr && (addr_i == OFF_DATA)),
    .wdata_i (wdata_i[TX_W-1:0]),
    .pop_i   (tx_pop_i),
    .rdata_o (tx_data_o),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  i2c_csr_fifo #(.W(RX_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (rx_push_i),
    .wdata_i (rx_data_i),
    .pop_i   (acc_rd && (addr_i == OFF_DATA)),
    .rdata_o (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  assign tx_valid_o = ~tx_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_empty_q <= 1'b1;
    else         tx_empty_q <= tx_empty;
  end

  always_comb begin
    irq_set         = '0;
    irq_set[IRQ_TE] = tx_empty & ~tx_empty_q;
    irq_set[IRQ_RB] = evt_rx_done_i;
    irq_set[IRQ_NA] = evt_nack_i;
    irq_set[IRQ_AL] = evt_arb_lost_i;
    irq_clr = (acc_wr && (addr_i == OFF_IRQ_CLR)) ? wdata_i[IRQ_W-1:0] : '0;
  end

  i2c_csr_irq #(.W(IRQ_W), .MASK(IRQ_MASK)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (irq_set),
    .clr_i      (irq_clr),
    .en_we_i    (acc_wr && (addr_i == OFF_IRQ_EN)),
    .en_wdata_i (wdata_i[IRQ_W-1:0]),
    .cause_o    (irq_cause),
    .en_o       (irq_en),
    .irq_o      (irq_o)
  );

  always_comb begin
    status_w         = '0;
    status_w[ST_DB]  = dev_busy_i;
    status_w[ST_BB]  = bus_busy_i;
    status_w[ST_RFF] = rx_full;
    status_w[ST_RNE] = ~rx_empty;
    status_w[ST_TNF] = ~tx_full;
    status_w[ST_TFE] = tx_empty;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL:   rdata_o = BUS_W'(ctrl_q);
      OFF_DATA:   rdata_o = rx_empty ? '0 : BUS_W'(rx_head);
      OFF_IRQ_ST: rdata_o = BUS_W'(irq_cause);
      OFF_IRQ_EN: rdata_o = BUS_W'(irq_en);
      OFF_STATUS: rdata_o = status_w;
      OFF_RST:    rdata_o = BUS_W'(bus_rst_o);
      OFF_TX_MON: rdata_o = BUS_W'(tx_cnt_mon_i);
      OFF_RX_MON: rdata_o = BUS_W'(rx_cnt_mon_i);
      default: begin
        for (int i = 0; i < NCFG; i++)
          if (addr_i == cfg_off(i)) rdata_o = BUS_W'(cfg_q[i]);
      end
    endcase
  end

  assert_ctrl_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |-> $past(req_i && we_i && (addr_i == OFF_CTRL)));

  assert_te_after_drain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty) |=> irq_cause[IRQ_TE]);
endmodule

// File: tb/i2c_host_csr_bench.sv
module i2c_host_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  ctrl;
  logic        ctrl_wr;
  logic [15:0] slave_addr, scl_cycle, scl_low, setup_rs, setup_dat, tx_bytes, rx_bytes, bus_ctl;
  logic        tx_valid;
  logic [8:0]  tx_data;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        ev_rb = 1'b0, ev_na = 1'b0, ev_al = 1'b0;
  logic        dev_busy = 1'b0, bus_busy = 1'b0;
  logic        bus_rst, bus_rst_done = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  i2c_host_csr u_i2c_host_csr (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ctrl_o(ctrl), .ctrl_wr_o(ctrl_wr),
    .slave_addr_o(slave_addr), .scl_cycle_o(scl_cycle), .scl_low_o(scl_low),
    .setup_rs_o(setup_rs), .setup_dat_o(setup_dat), .tx_bytes_o(tx_bytes),
    .rx_bytes_o(rx_bytes), .bus_ctl_o(bus_ctl), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_pop_i(tx_pop), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .evt_rx_done_i(ev_rb), .evt_nack_i(ev_na), .evt_arb_lost_i(ev_al),
    .dev_busy_i(dev_busy), .bus_busy_i(bus_busy), .bus_rst_o(bus_rst),
    .bus_rst_done_i(bus_rst_done), .tx_cnt_mon_i(16'h0055), .rx_cnt_mon_i(16'h00AA),
    .irq_o(irq)
  );

  // {write, addr, data, expected read}
  localparam int NV = 16;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h0C, 32'hFFFF_ABCD, 32'h0},         // R2
    {1'b0, 8'h0C, 32'h0, 32'h0000_ABCD},
    {1'b1, 8'h10, 32'h0000_007D, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h0000_007D},
    {1'b1, 8'h50, 32'h0000_0003, 32'h0},
    {1'b0, 8'h50, 32'h0, 32'h0000_0003},
    {1'b1, 8'h3C, 32'h1234_5A5A, 32'h0},
    {1'b0, 8'h3C, 32'h0, 32'h0000_5A5A},
    {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},         // R2 unused offsets
    {1'b0, 8'h08, 32'h0, 32'h0},
    {1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h30, 32'h0, 32'h0},
    {1'b1, 8'h48, 32'h0000_1234, 32'h0},         // R12 monitors ignore writes
    {1'b0, 8'h48, 32'h0, 32'h0000_0055},
    {1'b1, 8'h4C, 32'h0000_4321, 32'h0},
    {1'b0, 8'h4C, 32'h0, 32'h0000_00AA}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v, exp, tag);
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_push = 1'b1; rx_data = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk({31'b0, irq}, 32'h0, "R1 irq");
    chk({31'b0, bus_rst}, 32'h0, "R1 bus_rst");
    chk({31'b0, tx_valid}, 32'h0, "R1 tx_valid");
    rd_chk(8'h2C, 32'h3, "R1 status");
    rd_chk(8'h00, 32'h0, "R1 ctrl");
    rd_chk(8'h0C, 32'h0, "R1 slave addr");
    rd_chk(8'h20, 32'h0, "R1 causes");

    // R2 R12 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else rd_chk(VEC[i][71:64], VEC[i][31:0], $sformatf("R2/R12 vector %0d", i));
    end
    #1;
    chk({16'b0, slave_addr}, 32'hABCD, "R2 slave_addr_o");
    chk({16'b0, scl_cycle}, 32'h7D, "R2 scl_cycle_o");
    chk({16'b0, bus_ctl}, 32'h3, "R2 bus_ctl_o");

    // R11 control write strobe
    wr(8'h00, 32'hFFFF_FFFC);
    #1;
    chk({31'b0, ctrl_wr}, 32'h1, "R11 strobe high");
    chk({28'b0, ctrl}, 32'hC, "R11 ctrl_o");
    @(negedge clk); #1;
    chk({31'b0, ctrl_wr}, 32'h0, "R11 strobe one cycle");
    rd_chk(8'h00, 32'hC, "R11 ctrl readback");

    // R3 transmit queue order and tag bit
    wr(8'h04, 32'h0000_01A5);
    wr(8'h04, 32'h0000_0033);
    #1;
    chk({31'b0, tx_valid}, 32'h1, "R3 tx_valid");
    chk({23'b0, tx_data}, 32'h1A5, "R3 head tagged");
    rd_chk(8'h2C, 32'h2, "R5 status tx partial");
    pop_tx();
    #1 chk({23'b0, tx_data}, 32'h033, "R3 second entry");
    pop_tx();
    wr(8'h28, 32'h0000_0216);
    rd_chk(8'h20, 32'h0, "R7 clear all");

    // R3 fill, overflow ignored, R6 drain sets TE
    for (int k = 0; k < 8; k++) wr(8'h04, 32'(k * 33 + 1));
    rd_chk(8'h2C, 32'h0, "R5 status tx full");
    wr(8'h04, 32'h0000_00FF);
    for (int k = 0; k < 8; k++) begin
      #1 chk({23'b0, tx_data}, 32'(k * 33 + 1), $sformatf("R3 order %0d", k));
      pop_tx();
    end
    #1 chk({31'b0, tx_valid}, 32'h0, "R3 overflow push dropped");
    rd_chk(8'h20, 32'h200, "R6 TE after drain");

    // R8 enable gating
    #1 chk({31'b0, irq}, 32'h0, "R8 irq masked");
    wr(8'h24, 32'hFFFF_FFFF);
    #1 chk({31'b0, irq}, 32'h1, "R8 irq enabled");
    rd_chk(8'h24, 32'h216, "R8 enable bits");

    // R7 set wins over clear
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h28; wdata = 32'h204; ev_na = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0; ev_na = 1'b0;
    rd_chk(8'h20, 32'h004, "R7 set wins");

    // R6 event causes, read-only cause register
    @(negedge clk); ev_rb = 1'b1; ev_al = 1'b1;
    @(negedge clk); ev_rb = 1'b0; ev_al = 1'b0;
    wr(8'h20, 32'h0);
    rd_chk(8'h20, 32'h016, "R6 causes sticky");
    wr(8'h28, 32'h016);
    #1 chk({31'b0, irq}, 32'h0, "R8 irq drops");
    rd_chk(8'h28, 32'h0, "R7 clear reads 0");

    // R4 receive queue
    push_rx(8'h11);
    push_rx(8'h22);
    rd_chk(8'h2C, 32'h7, "R5 rx not empty");
    rd_chk(8'h04, 32'h11, "R4 first byte");
    rd_chk(8'h04, 32'h22, "R4 second byte");
    rd_chk(8'h04, 32'h0, "R4 empty read");
    rd_chk(8'h2C, 32'h3, "R4 empty after reads");
    for (int k = 1; k <= 9; k++) push_rx(8'(8'h30 + k));
    rd_chk(8'h2C, 32'hF, "R5 rx full");
    for (int k = 1; k <= 8; k++) rd_chk(8'h04, 32'(8'h30 + k), $sformatf("R4 order %0d", k));
    rd_chk(8'h04, 32'h0, "R4 overflow byte dropped");

    // R9 flushes
    wr(8'h04, 32'h0AA);
    wr(8'h04, 32'h055);
    push_rx(8'h44);
    push_rx(8'h55);
    rd_chk(8'h2C, 32'h6, "R9 before flush");
    wr(8'h34, 32'h4);
    rd_chk(8'h2C, 32'h7, "R9 tx flushed");
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h34; wdata = 32'h2; rx_push = 1'b1; rx_data = 8'h66;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0; rx_push = 1'b0;
    rd_chk(8'h2C, 32'h3, "R9 flush wins over push");
    rd_chk(8'h34, 32'h0, "R9 flush bits read 0");

    // R10 forced bus reset
    wr(8'h34, 32'h1);
    #1 chk({31'b0, bus_rst}, 32'h1, "R10 bus_rst_o high");
    rd_chk(8'h34, 32'h1, "R10 reads 1");
    wr(8'h34, 32'h0);
    rd_chk(8'h34, 32'h1, "R10 write 0 no effect");
    @(negedge clk); bus_rst_done = 1'b1;
    @(negedge clk); bus_rst_done = 1'b0;
    #1 chk({31'b0, bus_rst}, 32'h0, "R10 bus_rst_o low");
    rd_chk(8'h34, 32'h0, "R10 self cleared");

    // R5 busy flags
    dev_busy = 1'b1; bus_busy = 1'b1;
    rd_chk(8'h2C, 32'h1103, "R5 busy bits");
    dev_busy = 1'b0; bus_busy = 1'b0;
    rd_chk(8'h2C, 32'h3, "R5 busy cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule